// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit derives the largest vector length the hardware can offer from the number of integer and floating-point registers each vector element consumes. The two physical register pools have fixed sizes. For each pool whose per-element usage is nonzero, the unit divides the pool size less one by the usage less one. The smaller of those quotients becomes the maximum, and the result is then capped at the number of micro-thread slots. When neither pool is used, the maximum falls back to a fixed default.

Software first sends a configure command and then a set-length command. The set-length command requests an application vector length, and the unit grants the smaller of that request and the current maximum. The quotients come from a bit-serial restoring divider, one quotient bit per clock. The unit therefore runs a configure for several cycles and reports this with `busy` and a one-cycle `done` pulse.

Both commands use valid/ready. A command transfers on a rising clock edge where its valid and ready are both high. Once valid is raised, the sender must hold valid and the payload steady until the transfer. The unit drops ready to apply back-pressure. It never takes a new configure while one is in progress, and it holds off a set-length command until the configure has finished.

Top module: `vlen_cfg_unit`

## Requirements
- R1: After reset, `max_len` is 8, `vec_len` is 0, `busy` and `done` are 0, and `cfg_ready` is 1.
- R2: A configure with both usage counts equal to 0 sets `max_len` to 8.
- R3: A configure with float usage 0 and integer usage u ≥ 2 sets `max_len` to min(floor((TOTAL_INT−1)/(u−1)), SLOTS). With the default totals of 256 this is 255/(u−1), and it can be 0.
- R4: A configure with integer usage 0 and float usage u ≥ 2 sets `max_len` to min(floor((TOTAL_FP−1)/(u−1)), SLOTS).
- R5: A configure with both usage counts nonzero sets `max_len` to the smaller of the two pool limits. In every case `max_len` never exceeds SLOTS (32 by default).
- R6: A usage count of exactly 1 gives that pool an unbounded limit, so the limit that side contributes is SLOTS.
- R7: A set-length transfer sets `vec_len` to min(`max_len`, `len_req`) on the clock edge of the transfer, so the new value is visible in the following cycle. `max_len` is left unchanged.
- R8: `cfg_ready` equals not `busy`. After a configure transfer, `busy` stays high for CNT_W+1 cycles (10 by default). Then `max_len` takes its new value, `busy` falls, and `done` is high for exactly one cycle.
- R9: `len_ready` is low while `busy` is high, and also in any idle cycle where `cfg_valid` is high, so configure wins a tie. A held set-length command transfers after `done` and uses the new maximum.
- R10: A configure does not change `vec_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configure command present |
| cfg_ready | output | 1 | Unit can accept a configure |
| cfg_int_used | input | CNT_W | Integer registers used per element |
| cfg_fp_used | input | CNT_W | Float registers used per element |
| len_valid | input | 1 | Set-length command present |
| len_ready | output | 1 | Unit can accept a set-length |
| len_req | input | REQ_W | Requested application vector length |
| max_len | output | LEN_W | Current maximum vector length |
| vec_len | output | LEN_W | Granted vector length |
| busy | output | 1 | Configure division in progress |
| done | output | 1 | One-cycle pulse when a new maximum lands |

## Verification
The bench exercises a usage count of 1. A design that divided by the zero divisor would report an all-ones quotient instead of the slot cap. It also uses usage counts large enough that the quotient drops to 0, and small counts whose quotient exceeds the cap, which catch a missing or misplaced clamp. It sends a set-length command during a configure and in the same cycle as one. A unit that let the request through early would grant against the stale maximum. Finally, it times `done` exactly, which exposes a divider that runs one step too many or too few.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } vlc_state_e;
endpackage

// File: rtl/vlc_divider.sv
// Bit-serial restoring divider: one quotient bit per clock, W steps.
module vlc_divider #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r;
  logic [W-1:0]  d_r;
  logic [W:0]    rem_r;
  logic [CW-1:0] cnt_r;
  logic          run_r;
  logic [W:0]    rem_sh;
  logic [W:0]    trial;

  always_comb begin
    rem_sh = {rem_r[W-1:0], q_r[W-1]};
    trial  = rem_sh - {1'b0, d_r};
  end

  assign fin  = run_r && (cnt_r == CW'(1));
  assign quot = q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      d_r   <= '0;
      rem_r <= '0;
      cnt_r <= '0;
      run_r <= 1'b0;
    end else if (start) begin
      q_r   <= dividend;
      d_r   <= divisor;
      rem_r <= '0;
      cnt_r <= CW'(W);
      run_r <= 1'b1;
    end else if (run_r) begin
      if (trial[W]) begin
        rem_r <= rem_sh;
        q_r   <= {q_r[W-2:0], 1'b0};
      end else begin
        rem_r <= trial;
        q_r   <= {q_r[W-2:0], 1'b1};
      end
      cnt_r <= cnt_r - CW'(1);
      if (cnt_r == CW'(1)) run_r <= 1'b0;
    end
  end

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_r && d_r != '0) |-> (rem_r < {1'b0, d_r}));

  // R8
  step_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_r |-> (cnt_r != '0));

  // R8
  quot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_r && !start) |=> $stable(q_r));
endmodule

// File: rtl/vlc_limit_sel.sv
// Chooses the maximum vector length from the two pool quotients.
module vlc_limit_sel #(
  parameter int W        = 9,
  parameter int LEN_W    = 6,
  parameter int SLOTS    = 32,
  parameter int IDLE_MAX = 8
) (
  input  logic [W-1:0]     int_used,
  input  logic [W-1:0]     fp_used,
  input  logic [W-1:0]     q_int,
  input  logic [W-1:0]     q_fp,
  output logic [LEN_W-1:0] max_out
);
  localparam int XW = ((W > LEN_W) ? W : LEN_W) + 1;

  logic [XW-1:0] cap;
  logic [XW-1:0] lim_int;
  logic [XW-1:0] lim_fp;
  logic [XW-1:0] pick;

  always_comb begin
    cap     = XW'(SLOTS);
    lim_int = (int_used == W'(1)) ? cap : XW'(q_int);
    lim_fp  = (fp_used  == W'(1)) ? cap : XW'(q_fp);
    unique case ({int_used == '0, fp_used == '0})
      2'b11:   pick = XW'(IDLE_MAX);
      2'b01:   pick = lim_int;
      2'b10:   pick = lim_fp;
      default: pick = (lim_int < lim_fp) ? lim_int : lim_fp;
    endcase
    max_out = LEN_W'((pick > cap) ? cap : pick);
  end
endmodule

// File: rtl/vlen_cfg_unit.sv
module vlen_cfg_unit #(
  parameter int CNT_W     = 9,
  parameter int REQ_W     = 16,
  parameter int SLOTS     = 32,
  parameter int TOTAL_INT = 256,
  parameter int TOTAL_FP  = 256,
  parameter int IDLE_MAX  = 8,
  localparam int LEN_W    = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CNT_W-1:0] cfg_int_used,
  input  logic [CNT_W-1:0] cfg_fp_used,
  input  logic             len_valid,
  output logic             len_ready,
  input  logic [REQ_W-1:0] len_req,
  output logic [LEN_W-1:0] max_len,
  output logic [LEN_W-1:0] vec_len,
  output logic             busy,
  output logic             done
);
  import vlc_pkg::*;

  localparam int CW = (REQ_W > LEN_W) ? REQ_W : LEN_W;

  vlc_state_e       state_r;
  logic [CNT_W-1:0] used_r [2];
  logic [CNT_W-1:0] used_in [2];
  logic [CNT_W-1:0] quot [2];
  logic             fin [2];
  logic [LEN_W-1:0] max_r;
  logic [LEN_W-1:0] vec_r;
  logic [LEN_W-1:0] sel_max;
  logic             done_r;
  logic             cfg_fire;
  logic             len_fire;
  logic [CW-1:0]    req_w;
  logic [CW-1:0]    max_w;

  assign used_in[0] = cfg_int_used;
  assign used_in[1] = cfg_fp_used;

  assign busy      = (state_r != ST_IDLE);
  assign cfg_ready = !busy;
  assign len_ready = !busy && !cfg_valid;
  assign cfg_fire  = cfg_valid && cfg_ready;
  assign len_fire  = len_valid && len_ready;
  assign max_len   = max_r;
  assign vec_len   = vec_r;
  assign done      = done_r;

  for (genvar g = 0; g < 2; g++) begin : g_pool
    localparam int TOT = (g == 0) ? TOTAL_INT : TOTAL_FP;
    vlc_divider #(.W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cfg_fire),
      .dividend (CNT_W'(TOT - 1)),
      .divisor  (used_in[g] - CNT_W'(1)),
      .quot     (quot[g]),
      .fin      (fin[g])
    );
  end

  vlc_limit_sel #(
    .W(CNT_W), .LEN_W(LEN_W), .SLOTS(SLOTS), .IDLE_MAX(IDLE_MAX)
  ) u_sel (
    .int_used (used_r[0]),
    .fp_used  (used_r[1]),
    .q_int    (quot[0]),
    .q_fp     (quot[1]),
    .max_out  (sel_max)
  );

  always_comb begin
    req_w = CW'(len_req);
    max_w = CW'(max_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_r   <= ST_IDLE;
      used_r[0] <= '0;
      used_r[1] <= '0;
      max_r     <= LEN_W'(IDLE_MAX);
      vec_r     <= '0;
      done_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (state_r)
        ST_IDLE: if (cfg_fire) begin
          used_r[0] <= cfg_int_used;
          used_r[1] <= cfg_fp_used;
          state_r   <= ST_DIV;
        end
        ST_DIV: if (fin[0] && fin[1]) state_r <= ST_FIN;
        ST_FIN: begin
          max_r   <= sel_max;
          done_r  <= 1'b1;
          state_r <= ST_IDLE;
        end
        default: state_r <= ST_IDLE;
      endcase
      if (len_fire) vec_r <= (req_w > max_w) ? max_r : LEN_W'(len_req);
    end
  end

  // R9
  len_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !len_ready);

  // R5
  max_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_len <= LEN_W'(SLOTS));

  // R7
  grant_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_fire |=> (vec_len <= $past(max_len)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(vec_len));
endmodule

// File: tb/tb_vlen_cfg_unit.sv
module tb_vlen_cfg_unit;
  localparam int CNT_W = 9;
  localparam int REQ_W = 16;
  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_valid = 1'b0;
  logic             cfg_ready;
  logic [CNT_W-1:0] cfg_int_used = '0;
  logic [CNT_W-1:0] cfg_fp_used = '0;
  logic             len_valid = 1'b0;
  logic             len_ready;
  logic [REQ_W-1:0] len_req = '0;
  logic [LEN_W-1:0] max_len;
  logic [LEN_W-1:0] vec_len;
  logic             busy;
  logic             done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vlen_cfg_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_int_used(cfg_int_used), .cfg_fp_used(cfg_fp_used),
    .len_valid(len_valid), .len_ready(len_ready), .len_req(len_req),
    .max_len(max_len), .vec_len(vec_len), .busy(busy), .done(done)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pool_lim(int u);
    if (u == 1) return 1 << 20;
    return 255 / (u - 1);
  endfunction

  function automatic int exp_max(int iu, int fu);
    int m;
    if (iu == 0 && fu == 0) m = 8;
    else if (fu == 0) m = pool_lim(iu);
    else if (iu == 0) m = pool_lim(fu);
    else m = (pool_lim(iu) < pool_lim(fu)) ? pool_lim(iu) : pool_lim(fu);
    return (m > 32) ? 32 : m;
  endfunction

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk("R1 max_len", int'(max_len), 8);
    chk("R1 vec_len", int'(vec_len), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cfg_ready", int'(cfg_ready), 1);
  endtask

  task automatic t_config(string req, int iu, int fu);
    int n;
    int v0;
    v0 = int'(vec_len);
    cfg_int_used = CNT_W'(iu);
    cfg_fp_used  = CNT_W'(fu);
    cfg_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R8 busy after accept", int'(busy), 1);
    chk("R8 cfg_ready low", int'(cfg_ready), 0);
    wait_done(n);
    chk("R8 latency", n, CNT_W + 1);
    chk({req, " max_len"}, int'(max_len), exp_max(iu, fu));
    chk("R8 busy cleared", int'(busy), 0);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    chk("R10 vec_len kept", int'(vec_len), v0);
  endtask

  task automatic t_set_len(int req);
    int m;
    m = int'(max_len);
    len_req   = REQ_W'(req);
    len_valid = 1'b1;
    chk("R7 len_ready idle", int'(len_ready), 1);
    @(posedge clk);
    @(negedge clk);
    len_valid = 1'b0;
    chk("R7 vec_len", int'(vec_len), (req < m) ? req : m);
    chk("R7 max_len unchanged", int'(max_len), m);
  endtask

  task automatic t_held_len();
    int waits = 0;
    cfg_int_used = CNT_W'(9);
    cfg_fp_used  = '0;
    cfg_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    len_req   = REQ_W'(40);
    len_valid = 1'b1;
    while (!len_ready && waits < 50) begin
      chk("R9 held while busy", int'(len_ready), int'(!busy));
      @(negedge clk);
      waits++;
    end
    chk("R9 max before grant", int'(max_len), 31);
    @(posedge clk);
    @(negedge clk);
    len_valid = 1'b0;
    chk("R9 grant uses new max", int'(vec_len), 31);
  endtask

  task automatic t_tie();
    int n;
    cfg_int_used = CNT_W'(2);
    cfg_fp_used  = CNT_W'(65);
    cfg_valid    = 1'b1;
    len_req      = REQ_W'(20);
    len_valid    = 1'b1;
    #1;
    chk("R9 tie len_ready", int'(len_ready), 0);
    chk("R9 tie cfg_ready", int'(cfg_ready), 1);
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    wait_done(n);
    chk("R6 tie max", int'(max_len), 3);
    @(posedge clk);
    @(negedge clk);
    len_valid = 1'b0;
    chk("R9 tie grant", int'(vec_len), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_len(5);
    t_config("R2", 0, 0);
    t_config("R3", 9, 0);
    t_config("R3", 17, 0);
    t_config("R3", 2, 0);
    t_config("R4", 0, 33);
    t_config("R4", 0, 5);
    t_config("R5", 9, 17);
    t_config("R5", 2, 2);
    t_set_len(10);
    t_set_len(32);
    t_set_len(1000);
    t_set_len(0);
    t_config("R6", 1, 0);
    t_config("R6", 0, 1);
    t_config("R6", 1, 65);
    t_config("R5", 17, 9);
    t_set_len(1000);
    t_set_len(15);
    t_config("R3", 300, 0);
    t_set_len(7);
    t_held_len();
    t_tie();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule